// File: doc/BRIEF.md
# Sleep Power-Down Sequencer

This block sequences a synchronous memory device into and out of its low-power sleep state. An asynchronous sleep pin is brought into the clock domain through a chain of flip-flops. Once the request is seen, the sequencer stops accepting new accesses at once. It then lets the device settle for a fixed number of cycles before it declares sleep. While asleep, and for a while after waking, the data bus is held in high impedance.

When the pin is released, the sequencer leaves sleep and counts a recovery window. During that window every attempted access is refused, so it behaves as a deselect. After the window the ready flag returns. The bus stays in high impedance until the first accepted read. A memory core uses `ready` and `grant` to gate its access decode, and uses `force_hiz` to override its output enable.

Top module: `sleepseq_ctrl`

## Requirements
- R1: Reset, which is asynchronous and active low, puts the block in the awake state with `ready`=1, `sleep_active`=0 and `force_hiz`=0, even when it arrives during sleep.
- R2: Suppose `sleep_pin` rises between two clock edges. `ready` then falls at the (SYNC_STAGES+1)-th rising edge after that change and not earlier.
- R3: `sleep_active` rises exactly ENTRY_CYCLES edges after `ready` falls. `force_hiz` rises on that same edge.
- R4: `grant` equals `acc_valid && ready`. While `ready` is 0, during entry, sleep or recovery, `grant` stays 0 for every value of `acc_valid` and `acc_read`.
- R5: Suppose `sleep_pin` falls between two edges while the block is asleep. `sleep_active` falls at the (SYNC_STAGES+1)-th edge after that change, and `ready` rises exactly EXIT_CYCLES edges later.
- R6: `force_hiz` stays 1 through recovery and into the awake state. It falls only at the edge that samples an accepted read (`grant`=1 with `acc_read`=1). Accepted writes (`acc_read`=0) and reads refused while not ready leave it at 1.
- R7: Once entry has begun, it always completes into sleep, even if the synchronized request drops during the entry window. Recovery then follows.
- R8: If the synchronized request is high again during recovery, the block returns to sleep at the next edge and `ready` never rises.
- R9: `ready` and `sleep_active` are never 1 together, and `sleep_active`=1 implies `force_hiz`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_pin | input | 1 | Asynchronous sleep request, high requests sleep |
| acc_valid | input | 1 | An access is attempted this cycle |
| acc_read | input | 1 | The attempted access is a read (1) or a write (0) |
| ready | output | 1 | Block is awake and accepts new accesses |
| grant | output | 1 | The attempted access is accepted this cycle |
| sleep_active | output | 1 | Device is in the power-down state |
| force_hiz | output | 1 | Forces the data bus to high impedance |

## Verification
The bench counts edges from each pin change. It checks the last cycle before each flag moves and the first cycle after it. A design with one synchronizer stage too few or too many, or an off-by-one settle counter, therefore misses by exactly one cycle.

Several cases are aimed at specific faults:
- The pin is dropped in the middle of entry. A design that aborted entry would never show `sleep_active`.
- The pin is raised again during recovery. A design that ignored it would briefly raise `ready`.
- Reads are attempted during recovery, and a write is accepted before the first read. A design that freed the bus too early would drop `force_hiz` ahead of the accepted read.

// File: rtl/sleepseq_pkg.sv
package sleepseq_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE   = 2'd0,
        ST_ENTER   = 2'd1,
        ST_ASLEEP  = 2'd2,
        ST_RECOVER = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       hiz;
    } seq_regs_t;

endpackage

// File: rtl/sleepseq_sync.sv
module sleepseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/sleepseq_timer.sv
module sleepseq_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)               cnt_d = load_val;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        else                    cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sleepseq_ctrl.sv
module sleepseq_ctrl
    import sleepseq_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int ENTRY_CYCLES = 2,
    parameter int EXIT_CYCLES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_pin,
    input  logic acc_valid,
    input  logic acc_read,
    output logic ready,
    output logic grant,
    output logic sleep_active,
    output logic force_hiz
);

    localparam int MAX_WIN = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
    localparam int CNT_W   = (MAX_WIN < 2) ? 1 : $clog2(MAX_WIN);
    localparam logic [CNT_W-1:0] ENTRY_LV = CNT_W'(ENTRY_CYCLES - 1);
    localparam logic [CNT_W-1:0] EXIT_LV  = CNT_W'(EXIT_CYCLES - 1);

    logic             req_s;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    seq_regs_t        regs_d, regs_q;

    sleepseq_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sleep_pin),
        .sync_out (req_s)
    );

    sleepseq_timer #(.W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign ready        = (regs_q.st == ST_AWAKE);
    assign sleep_active = (regs_q.st == ST_ASLEEP);
    assign force_hiz    = regs_q.hiz;
    assign grant        = acc_valid && ready;

    always_comb begin
        regs_d   = regs_q;
        tmr_load = 1'b0;
        tmr_val  = ENTRY_LV;
        unique case (regs_q.st)
            ST_AWAKE: begin
                if (req_s) begin
                    regs_d.st = ST_ENTER;
                    tmr_load  = 1'b1;
                    tmr_val   = ENTRY_LV;
                end
            end
            ST_ENTER: begin
                if (tmr_done) begin
                    regs_d.st  = ST_ASLEEP;
                    regs_d.hiz = 1'b1;
                end
            end
            ST_ASLEEP: begin
                if (!req_s) begin
                    regs_d.st = ST_RECOVER;
                    tmr_load  = 1'b1;
                    tmr_val   = EXIT_LV;
                end
            end
            ST_RECOVER: begin
                if (req_s)         regs_d.st = ST_ASLEEP;
                else if (tmr_done) regs_d.st = ST_AWAKE;
            end
            default: regs_d.st = ST_AWAKE;
        endcase
        if (grant && acc_read) regs_d.hiz = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.st  <= ST_AWAKE;
            regs_q.hiz <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R4: no access is accepted while asleep
    p_no_grant_asleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_active |-> !grant);

    // R9: the bus is released whenever the device sleeps
    p_hiz_while_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_active |-> force_hiz);

    // R9: ready and sleep never overlap
    p_ready_sleep_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && sleep_active));

    // R3: sleep is reached only after new accesses were already blocked
    p_entry_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_active) |-> !$past(ready));

    // R5: ready never returns straight out of sleep
    p_exit_recover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> !$past(sleep_active));

    // R6: the bus override ends only after an accepted read
    p_hiz_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(force_hiz) |-> $past(grant && acc_read));

endmodule

// File: tb/test_sleepseq_ctrl.sv
module test_sleepseq_ctrl;

    localparam int SYNC = 2;
    localparam int ENT  = 2;
    localparam int EXT  = 2;
    localparam int L    = SYNC + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_pin = 1'b0;
    logic acc_valid = 1'b0;
    logic acc_read = 1'b0;
    logic ready, grant, sleep_active, force_hiz;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        int         at;
        string      tag;
        logic [3:0] mask;
        logic [3:0] val;
    } exp_t;

    exp_t sb[$];

    sleepseq_ctrl #(
        .SYNC_STAGES (SYNC),
        .ENTRY_CYCLES(ENT),
        .EXIT_CYCLES (EXT)
    ) i_sleepseq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_pin   (sleep_pin),
        .acc_valid   (acc_valid),
        .acc_read    (acc_read),
        .ready       (ready),
        .grant       (grant),
        .sleep_active(sleep_active),
        .force_hiz   (force_hiz)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // bit order {ready, grant, sleep_active, force_hiz}
    task automatic push(input int at, input string tag, input logic [3:0] mask, input logic [3:0] val);
        exp_t e;
        e.at = at; e.tag = tag; e.mask = mask; e.val = val;
        sb.push_back(e);
    endtask

    task automatic go(input int n);
        @(negedge clk);
        while (cyc < n) @(negedge clk);
        #1;
    endtask

    // monitor: samples late in the low phase, after inputs settle
    always @(negedge clk) begin
        #3;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            logic [3:0] obs;
            e = sb.pop_front();
            obs = {ready, grant, sleep_active, force_hiz};
            n_tests++;
            if (e.at < cyc) begin
                n_fail++;
                $display("FAIL %s: check for cycle %0d missed (now %0d), actual %b expected %b",
                         e.tag, e.at, cyc, obs & e.mask, e.val & e.mask);
            end else if ((obs & e.mask) !== (e.val & e.mask)) begin
                n_fail++;
                $display("FAIL %s: cycle %0d {rdy,gnt,slp,hiz} actual %b expected %b",
                         e.tag, cyc, obs & e.mask, e.val & e.mask);
            end
        end
    end

    initial begin
        int b, d, c, w;
        // R1: state right after reset release
        push(3, "R1", 4'b1011, 4'b1000);
        go(1);
        rst_n = 1'b1;
        go(4);

        // Scenario A: entry, sleep, recovery, write then read (R2 R3 R4 R5 R6)
        b = cyc + 1;
        d = b + L + ENT + 2;
        push(b + L - 1,       "R2", 4'b1111, 4'b1100);
        push(b + L,           "R2", 4'b1111, 4'b0000);
        push(b + L + ENT - 1, "R3", 4'b1010, 4'b0000);
        push(b + L + ENT,     "R3", 4'b1111, 4'b0011);
        push(d + L - 1,       "R5", 4'b0010, 4'b0010);
        push(d + L,           "R5", 4'b1111, 4'b0001);
        push(d + L + EXT - 1, "R4", 4'b1111, 4'b0001);
        push(d + L + EXT,     "R5", 4'b1111, 4'b1101);
        push(d + L + EXT + 1, "R6", 4'b0101, 4'b0101);
        push(d + L + EXT + 2, "R6", 4'b0001, 4'b0000);
        go(b);               sleep_pin = 1'b1; acc_valid = 1'b1; acc_read = 1'b0;
        go(d);               sleep_pin = 1'b0; acc_read = 1'b1;
        go(d + L + EXT - 1); acc_read = 1'b0;
        go(d + L + EXT + 1); acc_read = 1'b1;
        go(d + L + EXT + 2); acc_valid = 1'b0; acc_read = 1'b0;
        go(d + L + EXT + 4);

        // Scenario B: request dropped mid-entry, entry still completes (R7)
        b = cyc + 1;
        push(b + L + ENT,           "R7", 4'b0010, 4'b0010);
        push(b + L + ENT + 1,       "R7", 4'b1010, 4'b0000);
        push(b + L + ENT + 1 + EXT, "R7", 4'b1000, 4'b1000);
        go(b);         sleep_pin = 1'b1;
        go(b + L - 1); sleep_pin = 1'b0;
        go(b + L + ENT + EXT + 3);

        // Scenario C: request returns during recovery (R8 R9)
        b = cyc + 1;
        c = b + L + ENT + 1;
        push(b + L + ENT, "R3", 4'b0011, 4'b0011);
        push(c + L,       "R8", 4'b1010, 4'b0000);
        push(c + L + 1,   "R8", 4'b1010, 4'b0010);
        push(c + L + 3,   "R9", 4'b1011, 4'b0011);
        go(b);     sleep_pin = 1'b1;
        go(c);     sleep_pin = 1'b0;
        go(c + 1); sleep_pin = 1'b1;
        go(c + L + 4);

        // Scenario D: reset while asleep (R1)
        w = cyc + 1;
        go(w);
        rst_n = 1'b0; sleep_pin = 1'b0;
        push(w, "R1", 4'b1011, 4'b1000);
        push(w + 3, "R1", 4'b1011, 4'b1000);
        go(w + 1); rst_n = 1'b1;
        go(w + 5);

        while (sb.size() > 0) @(negedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule